// File: doc/BRIEF.md
# Write-Qualified Control Register Bank

This block holds the host-visible control registers of a communication controller. A 16-bit register port with two byte-lane enables reaches every field. Each field accepts a write only while its permission condition holds, and that condition can be an OR of several terms. The terms are:

- always;
- module disabled;
- module enabled;
- protocol engine in its configuration state;
- the related message buffer disabled;
- the related message buffer locked.

A write that fails its condition changes nothing and raises no flag. Some registers also refuse any access that is not a full 16-bit write.

The protocol engine is outside the block. Its state and the per-buffer enable and lock status arrive as inputs.

Two events clear fields:

- Writing the run command code to the protocol command field clears the run-cleared register.
- A buffer-disable handshake clears that buffer's locked payload field.

An indirect window register selects one of four internal registers through a 2-bit selector. A mode bit decides whether a write loads the selector and the selected register together, or the selector alone.

Top module: `wqrb_top`

Register map (4-bit word address):

| Address | Contents | Write condition |
|---|---|---|
| 0 | Control. Bit 0 is `mod_en`. Bits 7:4 are the command field, write-only, which reads 0. | Always |
| 1 | Timing word, 16 bits | Configuration state OR module disabled; full access only |
| 2 | Run-cleared word, 16 bits | Module enabled; each byte lane separately |
| 3 | Window. Bits 1:0 are the selector, bit 2 is the mode bit, bits 15:8 are the internal data. | Full access only |
| 4 + n | Buffer n. Bits 15:8 are the id, bits 7:4 the payload length, bit 0 the disable trigger (write-only). | See R7 to R9 |

## Requirements
- R1: After synchronous reset every readable register at addresses 0 to 5, and every internal window register, reads zero.
- R2: `mod_en` (address 0, bit 0, low lane) is writable at any time and reads back as written.
- R3: The timing word (address 1) takes a write when the protocol state equals the configuration code or `mod_en` is 0. Otherwise the write is ignored.
- R4: A write to address 1 or address 3 without both byte enables set is ignored.
- R5: The run-cleared word (address 2) takes each enabled byte lane only while `mod_en` is 1. Otherwise the write is ignored.
- R6: A low-lane write of command code 4'b0101 to bits 7:4 of address 0 clears the run-cleared word. Any other code leaves it unchanged.
- R7: A buffer id (bits 15:8 at 4+n) is written only while that buffer's enable status is 0.
- R8: A buffer payload length (bits 7:4 at 4+n) is written only while that buffer's lock status is 1.
- R9: The payload length is cleared when the buffer's enable status falls after a write of 1 to trigger bit 0 made while the enable status was 1. A trigger written while the enable status is 0 has no effect.
- R10: When the disable clear and a permitted payload-length write fall in the same cycle, the clear wins.
- R11: A full write to the window with mode bit 2 at 0 loads the selector and the selected internal register (from bits 15:8).
- R12: A full write to the window with mode bit 2 at 1 loads only the selector. All internal registers keep their values.
- R13: The window reads as {internal[selector], 5'b0, mode 0, selector}, so the mode bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for reads and writes |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte-lane enables (bit 1 = bits 15:8) |
| rdata | output | 16 | Combinational read data for `addr` |
| proto_state | input | 3 | Protocol engine state (configuration code 3'd2) |
| buf_en_sts | input | 2 | Per-buffer enable status |
| buf_lock_sts | input | 2 | Per-buffer lock status |

## Verification
The following properties are checked on every cycle:

- a write rejected by its gate, or a partial write, leaves the timing word unchanged;
- a rejected write leaves the run-cleared word unchanged, and the run command zeroes it;
- a buffer id does not move while its buffer is enabled;
- a payload length does not move while unlocked, and is zero after a disable grant;
- a mode-1 window write leaves the internal array untouched.

Only the bench scenarios can show the following:

- that permitted writes really land, per byte lane;
- that a trigger written while the buffer is already disabled arms nothing;
- the window read format;
- that the clear wins over a same-cycle write, as seen through the read port.

// File: rtl/wqrb_pkg.sv
package wqrb_pkg;

    // Permission terms; a field may be written when any set term is true
    typedef struct packed {
        logic any;
        logic dis;
        logic en;
        logic cfg;
        logic mbdis;
        logic mblck;
    } perm_t;

    // Live conditions the permission terms are evaluated against
    typedef struct packed {
        logic mod_en;
        logic in_cfg;
        logic buf_en;
        logic buf_lck;
    } ctx_t;

    localparam perm_t PERM_ANY    = '{any: 1'b1, default: 1'b0};
    localparam perm_t PERM_EN     = '{en: 1'b1, default: 1'b0};
    localparam perm_t PERM_CFGDIS = '{cfg: 1'b1, dis: 1'b1, default: 1'b0};
    localparam perm_t PERM_MBDIS  = '{mbdis: 1'b1, default: 1'b0};
    localparam perm_t PERM_MBLCK  = '{mblck: 1'b1, default: 1'b0};

    localparam logic [3:0] RUN_CMD = 4'b0101;

    localparam int A_CTRL   = 0;
    localparam int A_TIM    = 1;
    localparam int A_RUN    = 2;
    localparam int A_WIN    = 3;
    localparam int BUF_BASE = 4;

    function automatic logic perm_ok(perm_t p, ctx_t c);
        return p.any
             | (p.dis   & ~c.mod_en)
             | (p.en    &  c.mod_en)
             | (p.cfg   &  c.in_cfg)
             | (p.mbdis & ~c.buf_en)
             | (p.mblck &  c.buf_lck);
    endfunction

endpackage

// File: rtl/wqrb_field.sv
module wqrb_field
    import wqrb_pkg::*;
#(
    parameter int    W    = 8,
    parameter perm_t PERM = PERM_ANY
) (
    input  logic         clk,
    input  logic         rst,
    input  ctx_t         ctx,
    input  logic         hit,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;            // clear event outranks a write
        end else if (hit && perm_ok(PERM, ctx)) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/wqrb_buf_slot.sv
module wqrb_buf_slot
    import wqrb_pkg::*;
#(
    parameter int IDW = 8,
    parameter int LW  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mod_en,
    input  logic        in_cfg,
    input  logic        buf_en,
    input  logic        buf_lck,
    input  logic        hit,
    input  logic [15:0] wdata,
    input  logic [1:0]  be,
    output logic [15:0] rd
);

    localparam int LO = 4;

    ctx_t             ctx;
    logic             pend_q;
    logic             grant;
    logic             hit_hi;
    logic             hit_lo;
    logic [IDW-1:0]   id_q;
    logic [LW-1:0]    plen_q;

    assign ctx    = '{mod_en: mod_en, in_cfg: in_cfg, buf_en: buf_en, buf_lck: buf_lck};
    assign hit_hi = hit & be[1];
    assign hit_lo = hit & be[0];
    assign grant  = pend_q & ~buf_en;

    // Disable request is armed only while the buffer is enabled
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (grant) begin
            pend_q <= 1'b0;
        end else if (hit_lo && wdata[0] && buf_en) begin
            pend_q <= 1'b1;
        end
    end

    wqrb_field #(.W(IDW), .PERM(PERM_MBDIS)) u_id (
        .clk(clk), .rst(rst), .ctx(ctx), .hit(hit_hi),
        .wdata(wdata[15 -: IDW]), .clr(1'b0), .q(id_q)
    );

    wqrb_field #(.W(LW), .PERM(PERM_MBLCK)) u_plen (
        .clk(clk), .rst(rst), .ctx(ctx), .hit(hit_lo),
        .wdata(wdata[LO +: LW]), .clr(grant), .q(plen_q)
    );

    always_comb begin
        rd             = '0;
        rd[15 -: IDW]  = id_q;
        rd[LO +: LW]   = plen_q;
    end

    // R7
    id_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_hi && buf_en) |=> $stable(id_q));
    // R8
    plen_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_lo && !buf_lck && !grant) |=> $stable(plen_q));
    // R10
    grant_clr_chk: assert property (@(posedge clk) disable iff (rst)
        grant |=> (plen_q == '0));

endmodule

// File: rtl/wqrb_window.sv
module wqrb_window #(
    parameter int SELW = 2,
    parameter int IW   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_full,
    input  logic [15:0] wdata,
    output logic [15:0] rd
);

    localparam int NREG = 1 << SELW;
    localparam int WMD  = SELW;

    logic [SELW-1:0]           sel_q;
    logic [NREG-1:0][IW-1:0]   regs_q;
    logic [SELW-1:0]           wsel;

    assign wsel = wdata[SELW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            regs_q <= '0;
        end else if (wr_full) begin
            sel_q <= wsel;
            if (!wdata[WMD]) begin
                regs_q[wsel] <= wdata[15 -: IW];
            end
        end
    end

    always_comb begin
        rd              = '0;
        rd[SELW-1:0]    = sel_q;
        rd[15 -: IW]    = regs_q[sel_q];
    end

    // R12
    wmd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_full && wdata[WMD]) |=> $stable(regs_q));
    // R11
    wmd_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_full && !wdata[WMD]) |=> (rd == $past({wdata[15 -: IW], {(16-IW){1'b0}}} | {{(16-SELW){1'b0}}, wsel})));

endmodule

// File: rtl/wqrb_top.sv
module wqrb_top
    import wqrb_pkg::*;
#(
    parameter int              AW        = 4,
    parameter int              NBUF      = 2,
    parameter int              PSW       = 3,
    parameter logic [PSW-1:0]  CFG_STATE = 3'd2,
    parameter int              SELW      = 2,
    parameter int              IW        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [15:0]      wdata,
    input  logic [1:0]       be,
    output logic [15:0]      rdata,
    input  logic [PSW-1:0]   proto_state,
    input  logic [NBUF-1:0]  buf_en_sts,
    input  logic [NBUF-1:0]  buf_lock_sts
);

    localparam int NLANE = 2;

    ctx_t                    ctx;
    logic                    in_cfg;
    logic                    mod_en_q;
    logic                    full;
    logic                    run_cmd;
    logic [15:0]             tim_q;
    logic [15:0]             runcnt_q;
    logic [15:0]             win_rd;
    logic [NBUF-1:0]         buf_hit;
    logic [NBUF-1:0][15:0]   buf_rd;

    assign in_cfg  = (proto_state == CFG_STATE);
    assign ctx     = '{mod_en: mod_en_q, in_cfg: in_cfg, buf_en: 1'b0, buf_lck: 1'b0};
    assign full    = (be == 2'b11);
    assign run_cmd = wr_en && (addr == AW'(A_CTRL)) && be[0] && (wdata[7:4] == RUN_CMD);

    wqrb_field #(.W(1), .PERM(PERM_ANY)) u_mod_en (
        .clk(clk), .rst(rst), .ctx(ctx),
        .hit(wr_en && (addr == AW'(A_CTRL)) && be[0]),
        .wdata(wdata[0]), .clr(1'b0), .q(mod_en_q)
    );

    wqrb_field #(.W(16), .PERM(PERM_CFGDIS)) u_tim (
        .clk(clk), .rst(rst), .ctx(ctx),
        .hit(wr_en && (addr == AW'(A_TIM)) && full),
        .wdata(wdata), .clr(1'b0), .q(tim_q)
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_run_lane
        wqrb_field #(.W(8), .PERM(PERM_EN)) u_lane (
            .clk(clk), .rst(rst), .ctx(ctx),
            .hit(wr_en && (addr == AW'(A_RUN)) && be[l]),
            .wdata(wdata[l*8 +: 8]), .clr(run_cmd), .q(runcnt_q[l*8 +: 8])
        );
    end

    wqrb_window #(.SELW(SELW), .IW(IW)) u_win (
        .clk(clk), .rst(rst),
        .wr_full(wr_en && (addr == AW'(A_WIN)) && full),
        .wdata(wdata), .rd(win_rd)
    );

    for (genvar n = 0; n < NBUF; n++) begin : g_buf
        assign buf_hit[n] = wr_en && (addr == AW'(BUF_BASE + n));
        wqrb_buf_slot u_slot (
            .clk(clk), .rst(rst), .mod_en(mod_en_q), .in_cfg(in_cfg),
            .buf_en(buf_en_sts[n]), .buf_lck(buf_lock_sts[n]),
            .hit(buf_hit[n]), .wdata(wdata), .be(be), .rd(buf_rd[n])
        );
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(A_CTRL): rdata = {15'b0, mod_en_q};
            AW'(A_TIM):  rdata = tim_q;
            AW'(A_RUN):  rdata = runcnt_q;
            AW'(A_WIN):  rdata = win_rd;
            default: begin
                for (int n = 0; n < NBUF; n++) begin
                    if (addr == AW'(BUF_BASE + n)) rdata = buf_rd[n];
                end
            end
        endcase
    end

    // R6
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        run_cmd |=> (runcnt_q == '0));
    // R5
    run_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == AW'(A_RUN)) && !mod_en_q) |=> $stable(runcnt_q));
    // R3
    tim_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == AW'(A_TIM)) && !in_cfg && mod_en_q) |=> $stable(tim_q));
    // R4
    tim_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == AW'(A_TIM)) && !full) |=> $stable(tim_q));

endmodule

// File: tb/tb_wqrb_top.sv
`timescale 1ns/1ps
module tb_wqrb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic [15:0] rdata;
    logic [2:0]  proto_state = '0;
    logic [1:0]  buf_en_sts = '0;
    logic [1:0]  buf_lock_sts = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wqrb_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .be(be), .rdata(rdata), .proto_state(proto_state),
        .buf_en_sts(buf_en_sts), .buf_lock_sts(buf_lock_sts)
    );

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [3:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic t_reset;
        for (int a = 0; a < 6; a++) expect_rd("R1", 4'(a), 16'h0000);
        for (int s = 0; s < 4; s++) begin
            wr(4'd3, 16'(s) | 16'h0004, 2'b11);
            expect_rd("R1", 4'd3, 16'(s));
        end
        wr(4'd3, 16'h0004, 2'b11);
    endtask

    task automatic t_mod_en;
        wr(4'd0, 16'h0001, 2'b01);
        expect_rd("R2", 4'd0, 16'h0001);
        wr(4'd0, 16'h0000, 2'b01);
        expect_rd("R2", 4'd0, 16'h0000);
    endtask

    task automatic t_timing;
        wr(4'd0, 16'h0001, 2'b01);
        proto_state = 3'd1;
        wr(4'd1, 16'hBEEF, 2'b11);
        expect_rd("R3", 4'd1, 16'h0000);
        proto_state = 3'd2;
        wr(4'd1, 16'h1111, 2'b11);
        expect_rd("R3", 4'd1, 16'h1111);
        proto_state = 3'd1;
        wr(4'd0, 16'h0000, 2'b01);
        wr(4'd1, 16'h2222, 2'b11);
        expect_rd("R3", 4'd1, 16'h2222);
        wr(4'd1, 16'h3333, 2'b01);
        expect_rd("R4", 4'd1, 16'h2222);
        wr(4'd1, 16'h4444, 2'b10);
        expect_rd("R4", 4'd1, 16'h2222);
    endtask

    task automatic t_run;
        wr(4'd2, 16'h1234, 2'b11);
        expect_rd("R5", 4'd2, 16'h0000);
        wr(4'd0, 16'h0001, 2'b01);
        wr(4'd2, 16'h1234, 2'b11);
        expect_rd("R5", 4'd2, 16'h1234);
        wr(4'd2, 16'hFFAB, 2'b01);
        expect_rd("R5", 4'd2, 16'h12AB);
        wr(4'd0, 16'h0031, 2'b01);
        expect_rd("R6", 4'd2, 16'h12AB);
        wr(4'd0, 16'h0051, 2'b01);
        expect_rd("R6", 4'd2, 16'h0000);
        expect_rd("R2", 4'd0, 16'h0001);
    endtask

    task automatic t_buf;
        buf_en_sts = 2'b11; buf_lock_sts = 2'b00;
        wr(4'd4, 16'h3300, 2'b10);
        expect_rd("R7", 4'd4, 16'h0000);
        buf_en_sts = 2'b00;
        wr(4'd4, 16'h3300, 2'b10);
        expect_rd("R7", 4'd4, 16'h3300);
        wr(4'd5, 16'h5A00, 2'b10);
        expect_rd("R7", 4'd5, 16'h5A00);
        wr(4'd4, 16'h0050, 2'b01);
        expect_rd("R8", 4'd4, 16'h3300);
        buf_lock_sts = 2'b01;
        wr(4'd4, 16'h0070, 2'b01);
        expect_rd("R8", 4'd4, 16'h3370);
        // arm disable with buffer enabled and unlocked
        buf_en_sts = 2'b01; buf_lock_sts = 2'b00;
        wr(4'd4, 16'h0001, 2'b01);
        expect_rd("R9", 4'd4, 16'h3370);
        // grant and a permitted write collide
        buf_lock_sts = 2'b01;
        @(negedge clk);
        buf_en_sts = 2'b00;
        wr_en = 1'b1; addr = 4'd4; wdata = 16'h00F0; be = 2'b01;
        @(negedge clk);
        wr_en = 1'b0;
        expect_rd("R10", 4'd4, 16'h3300);
        wr(4'd4, 16'h0020, 2'b01);
        expect_rd("R9", 4'd4, 16'h3320);
        // trigger while disabled arms nothing
        buf_lock_sts = 2'b00;
        wr(4'd4, 16'h0001, 2'b01);
        buf_en_sts = 2'b01;
        @(negedge clk);
        buf_en_sts = 2'b00;
        @(negedge clk);
        @(negedge clk);
        expect_rd("R9", 4'd4, 16'h3320);
    endtask

    task automatic t_window;
        wr(4'd3, 16'hAB02, 2'b11);
        expect_rd("R11", 4'd3, 16'hAB02);
        wr(4'd3, 16'h5507, 2'b11);
        expect_rd("R12", 4'd3, 16'h0003);
        wr(4'd3, 16'h0006, 2'b11);
        expect_rd("R13", 4'd3, 16'hAB02);
        wr(4'd3, 16'hCC01, 2'b10);
        expect_rd("R4", 4'd3, 16'hAB02);
        wr(4'd3, 16'h1103, 2'b11);
        expect_rd("R11", 4'd3, 16'h1103);
        wr(4'd3, 16'h0006, 2'b11);
        expect_rd("R12", 4'd3, 16'hAB02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mod_en();
        t_timing();
        t_run();
        t_buf();
        t_window();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule